// File: doc/BRIEF.md
# Programmable Rate-Half Hard-Decision Viterbi Decoder

This block decodes a rate-1/2 convolutional code from hard-decision symbol pairs. The code memory and both generator polynomials are configuration inputs, so one instance can serve any code with memory 2 to 5. Each received pair runs one trellis step. A single add-compare-select datapath updates one trellis state per clock, so a step takes 2^m cycles.

Each state keeps its survivor path as a 20-bit shift register (register exchange). Path metrics and survivors live in two banks that swap roles at the end of every step. Metrics are normalised by subtracting the previous step's minimum. During the sweep the decoder tracks the state with the best metric. The oldest bit of that state's survivor becomes the decoded output for the step.

Both data interfaces use valid/ready. An input pair is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a step is being swept, while a decoded bit waits to be taken, and in any cycle where the configuration differs from the one in use. A decoded bit is taken on an edge where `out_valid` and `out_ready` are both high. Until then, `out_valid` and `out_bit` hold their values. The sink may keep `out_ready` low for as long as it needs, and the decoder stalls its input until the bit is taken.

Top module: `hd_viterbi_r2`

## Requirements
- R1: The memory order is `cfg_m`. A value below 2 is treated as 2, and a value above 5 is treated as 5. Bit i of a generator taps the input bit from i steps earlier, and bit 0 taps the current bit. `in_sym[1]` carries the `cfg_g0` parity and `in_sym[0]` carries the `cfg_g1` parity.
- R2: After reset, or in the cycle after any configuration input changes, `out_valid` is low and `in_ready` is high. Decoding then restarts from trellis state 0.
- R3: An error-free stream from any supported code decodes to the original information bits, for each memory order 2 to 5.
- R4: With memory 5, isolated single symbol-bit errors spaced 16 steps apart are corrected.
- R5: After a pair is accepted, `in_ready` stays low for exactly 2^m cycles while the states are swept.
- R6: No bit is output during the first 19 steps after a restart. From step 20 on, each step yields exactly one bit, and that bit is the information bit of the step 19 steps earlier.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` hold their values and `in_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_m | input | 3 | Code memory order (clamped to 2..5) |
| cfg_g0 | input | 6 | First generator, bit i taps input delayed by i |
| cfg_g1 | input | 6 | Second generator |
| in_valid | input | 1 | Symbol pair offered |
| in_ready | output | 1 | Decoder can accept a pair |
| in_sym | input | 2 | Hard symbol pair, bit 1 for g0, bit 0 for g1 |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Sink takes the decoded bit |
| out_bit | output | 1 | Decoded information bit |

## Verification
The assertions check the handshake rules on every cycle. A held output keeps its value and blocks input. An accepted pair drops `in_ready`. An output never appears before the truncation depth is reached. A configuration change clears any pending output. Decoding correctness needs an encoder model and end-to-end comparison, so only the bench scenarios can show it. The same holds for the exact sweep length per memory order, parameter clamping, and error correction.

// File: rtl/vd_pkg.sv
package vd_pkg;
  localparam int unsigned VD_MAX_M = 5;
  localparam int unsigned VD_TRUNC = 20;
  localparam int unsigned VD_PMW   = 6;
endpackage

// File: rtl/vd_bmu.sv
module vd_bmu #(
  parameter int unsigned MAX_M = 5
) (
  input  logic [MAX_M:0]   g0,
  input  logic [MAX_M:0]   g1,
  input  logic [MAX_M-1:0] st,
  input  logic             u,
  input  logic [1:0]       sym,
  output logic [1:0]       bm
);
  logic [MAX_M:0] win;
  logic c0, c1;

  always_comb begin
    win = {st, u};
    c0  = ^(g0 & win);
    c1  = ^(g1 & win);
    bm  = {1'b0, c0 ^ sym[1]} + {1'b0, c1 ^ sym[0]};
  end
endmodule

// File: rtl/vd_acs.sv
module vd_acs #(
  parameter int unsigned PMW = 6
) (
  input  logic [PMW-1:0] pm0,
  input  logic [PMW-1:0] pm1,
  input  logic [1:0]     bm0,
  input  logic [1:0]     bm1,
  output logic           sel,
  output logic [PMW-1:0] pm_new
);
  logic [PMW:0] s0, s1, win;

  always_comb begin
    s0  = {1'b0, pm0} + {{(PMW-1){1'b0}}, bm0};
    s1  = {1'b0, pm1} + {{(PMW-1){1'b0}}, bm1};
    sel = (s1 < s0);
    win = sel ? s1 : s0;
    pm_new = win[PMW] ? {PMW{1'b1}} : win[PMW-1:0];
  end
endmodule

// File: rtl/hd_viterbi_r2.sv
module hd_viterbi_r2 #(
  parameter int unsigned MAX_M = vd_pkg::VD_MAX_M,
  parameter int unsigned TRUNC = vd_pkg::VD_TRUNC,
  parameter int unsigned PMW   = vd_pkg::VD_PMW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(MAX_M+1)-1:0]    cfg_m,
  input  logic [MAX_M:0]                cfg_g0,
  input  logic [MAX_M:0]                cfg_g1,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [1:0]                    in_sym,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic                          out_bit
);
  localparam int unsigned NS  = 1 << MAX_M;
  localparam int unsigned IW  = MAX_M;
  localparam int unsigned MSW = $clog2(MAX_M+1);
  localparam int unsigned CW  = $clog2(TRUNC+1);

  logic [MSW-1:0]   m_q, m_eff;
  logic [MAX_M:0]   g0_q, g1_q;
  logic             cfg_chg;
  logic             busy, cur;
  logic [IW-1:0]    idx, last_idx, hi_bit;
  logic [IW:0]      one_sh;
  logic [1:0]       sym_q;
  logic [CW-1:0]    steps;
  logic [PMW-1:0]   min_prev, run_pm, fin_pm;
  logic             run_bit, fin_bit;

  logic [PMW-1:0]   pm_bank [2][NS];
  logic [TRUNC-1:0] sv_bank [2][NS];

  logic [IW-1:0]    pred [2];
  logic [PMW-1:0]   norm [2];
  logic [1:0]       bm   [2];
  logic             sel;
  logic [PMW-1:0]   pm_new;
  logic [IW-1:0]    psel;
  logic [TRUNC-1:0] sv_new;

  assign cfg_chg = (cfg_m != m_q) || (cfg_g0 != g0_q) || (cfg_g1 != g1_q);

  always_comb begin
    if (m_q < MSW'(2))          m_eff = MSW'(2);
    else if (m_q > MSW'(MAX_M)) m_eff = MSW'(MAX_M);
    else                        m_eff = m_q;
    one_sh   = (IW+1)'(1) << m_eff;
    last_idx = IW'(one_sh - 1'b1);
    hi_bit   = IW'(one_sh >> 1);
    pred[0]  = idx >> 1;
    pred[1]  = (idx >> 1) | hi_bit;
  end

  for (genvar b = 0; b < 2; b++) begin : g_branch
    assign norm[b] = pm_bank[cur][pred[b]] - min_prev;
    vd_bmu #(.MAX_M(MAX_M)) u_bmu (
      .g0(g0_q), .g1(g1_q), .st(pred[b]), .u(idx[0]), .sym(sym_q), .bm(bm[b])
    );
  end

  vd_acs #(.PMW(PMW)) u_acs (
    .pm0(norm[0]), .pm1(norm[1]), .bm0(bm[0]), .bm1(bm[1]),
    .sel(sel), .pm_new(pm_new)
  );

  always_comb begin
    psel   = sel ? pred[1] : pred[0];
    sv_new = {sv_bank[cur][psel][TRUNC-2:0], idx[0]};
    if (idx == '0 || pm_new < run_pm) begin
      fin_pm  = pm_new;
      fin_bit = sv_new[TRUNC-1];
    end else begin
      fin_pm  = run_pm;
      fin_bit = run_bit;
    end
  end

  assign in_ready = !busy && !out_valid && !cfg_chg;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_chg) begin
      m_q       <= cfg_m;
      g0_q      <= cfg_g0;
      g1_q      <= cfg_g1;
      busy      <= 1'b0;
      cur       <= 1'b0;
      idx       <= '0;
      sym_q     <= '0;
      steps     <= '0;
      min_prev  <= '0;
      run_pm    <= '0;
      run_bit   <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      for (int k = 0; k < NS; k++) begin
        for (int j = 0; j < 2; j++) begin
          pm_bank[j][k] <= (k == 0) ? '0 : {PMW{1'b1}};
          sv_bank[j][k] <= '0;
        end
      end
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (in_valid && in_ready) begin
        sym_q <= in_sym;
        busy  <= 1'b1;
        idx   <= '0;
      end
      if (busy) begin
        pm_bank[~cur][idx] <= pm_new;
        sv_bank[~cur][idx] <= sv_new;
        run_pm  <= fin_pm;
        run_bit <= fin_bit;
        idx     <= idx + 1'b1;
        if (idx == last_idx) begin
          busy     <= 1'b0;
          cur      <= ~cur;
          min_prev <= fin_pm;
          if (steps != CW'(TRUNC)) steps <= steps + 1'b1;
          if (steps >= CW'(TRUNC-1)) begin
            out_valid <= 1'b1;
            out_bit   <= fin_bit;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vd_chk.sv
module vd_chk #(
  parameter int unsigned MAX_M = 5,
  parameter int unsigned TRUNC = 20,
  parameter int unsigned CFGW  = 15,
  parameter int unsigned CW    = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CFGW-1:0] cfg_all,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_bit,
  input logic [CW-1:0]   steps
);
  // R7: a held output keeps its value
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));
  // R7: a pending output blocks the input side
  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R5: an accepted pair starts a sweep
  p_sweep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R6: output only after the truncation depth
  p_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (steps == CW'(TRUNC)));
  // R2: a configuration change clears pending output
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_all != $past(cfg_all)) |=> !out_valid);
endmodule

bind hd_viterbi_r2 vd_chk #(
  .MAX_M(MAX_M), .TRUNC(TRUNC), .CFGW(MSW + 2*(MAX_M+1)), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_all({cfg_m, cfg_g0, cfg_g1}),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_bit(out_bit), .steps(steps)
);

// File: tb/sim_hd_viterbi_r2.sv
`timescale 1ns/1ps
module sim_hd_viterbi_r2;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_m = 3'd2;
  logic [5:0] cfg_g0 = 6'o07, cfg_g1 = 6'o05;
  logic       in_valid = 1'b0, out_ready = 1'b1;
  logic [1:0] in_sym = 2'b00;
  logic       in_ready, out_valid, out_bit;

  int total = 0, bad = 0, out_cnt = 0;
  bit done = 0;
  bit expq[$];
  string cur_req = "R3";
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  hd_viterbi_r2 u0 (
    .clk(clk), .rst_n(rst_n), .cfg_m(cfg_m), .cfg_g0(cfg_g0), .cfg_g1(cfg_g1),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // monitor: pops expected bits as outputs are taken
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      out_cnt++;
      if (expq.size() == 0) check(1'b0, {cur_req, " extra output"}, out_bit, -1);
      else begin
        bit e;
        e = expq.pop_front();
        check(out_bit == e, cur_req, out_bit, e);
      end
    end
  end

  task automatic send(input logic [1:0] s, output int lowcnt);
    do @(negedge clk); while (!in_ready);
    in_valid = 1'b1;
    in_sym   = s;
    @(negedge clk);
    in_valid = 1'b0;
    lowcnt = 0;
    for (int i = 0; i < 200; i++) begin
      if (in_ready) break;
      lowcnt++;
      @(negedge clk);
    end
  endtask

  task automatic run(input int mcfg, input int mref, input logic [5:0] g0,
                     input logic [5:0] g1, input int n, input bit err, input bit bp,
                     input string req);
    int sreg = 0, lc, tmo;
    int mask = (1 << mref) - 1;
    @(negedge clk);
    cfg_m = 3'(mcfg); cfg_g0 = g0; cfg_g1 = g1;
    @(negedge clk);
    check(in_ready && !out_valid, "R2 restart", {in_ready, out_valid}, 2);
    out_cnt = 0;
    cur_req = req;
    for (int k = 0; k < n + 19; k++) begin
      bit u;
      int x;
      logic [1:0] s;
      u = (k < n) ? lfsr[0] : 1'b0;
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      if (k < n) expq.push_back(u);
      x = (sreg << 1) | int'(u);
      s = {^(6'(x) & g0), ^(6'(x) & g1)};
      sreg = x & mask;
      if (err && k < n && (k % 16) == 8) s[0] = ~s[0];
      if (bp && k == 19) out_ready = 1'b0;
      send(s, lc);
      if (k == 0) check(lc == (1 << mref), "R5 sweep length", lc, 1 << mref);
      if (k == 18) begin
        repeat ((1 << mref) + 4) @(negedge clk);
        check(out_cnt == 0 && !out_valid, "R6 early output", out_cnt, 0);
      end
      if (bp && k == 19) begin
        logic held;
        repeat ((1 << mref) + 3) @(negedge clk);
        held = out_bit;
        check(out_valid && !in_ready, "R7 held valid", {out_valid, in_ready}, 2);
        repeat (10) @(negedge clk);
        check(out_valid && !in_ready && out_bit == held, "R7 stable", out_bit, held);
        out_ready = 1'b1;
      end
    end
    tmo = 0;
    while (expq.size() != 0 && tmo < 2000) begin @(negedge clk); tmo++; end
    repeat (40) @(negedge clk);
    check(out_cnt == n, "R6 output count", out_cnt, n);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R2 reset", {in_ready, out_valid}, 2);
    run(2, 2, 6'o07, 6'o05, 40, 0, 0, "R3 m2");
    run(3, 3, 6'o15, 6'o17, 40, 0, 1, "R3 m3");
    run(4, 4, 6'o23, 6'o35, 40, 0, 0, "R3 m4");
    run(5, 5, 6'o53, 6'o75, 40, 0, 0, "R3 m5");
    run(5, 5, 6'o75, 6'o53, 48, 1, 0, "R4 errors");
    run(1, 2, 6'o05, 6'o07, 24, 0, 0, "R1 clamp low");
    run(7, 5, 6'o53, 6'o75, 24, 0, 0, "R1 clamp high");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule